// File: doc/BRIEF.md
# Rotating Tiled-View Address Generator

This unit converts a pixel coordinate into an address inside a tiled two-dimensional memory space. Each request carries a pixel size code (8-bit, 16-bit, 32-bit or page mode), a 3-bit view code that selects one of eight rotated or mirrored views, and the X and Y coordinates. The unit returns a 32-bit address, a flag that tells whether the coordinate lies inside the container, and the line stride that goes with the selected view.

Bits of the coordinate that the pixel size makes redundant are dropped, so wider pixels have fewer coordinate bits. Mirroring inverts a coordinate against its full range, and a transposed view swaps the roles of X and Y before they are packed. The packed offset is scaled back up by the dropped bits, and the view and size codes are placed in the top five address bits. With the default parameters a result appears one clock after the request.

Top module: `tiled_view_addr`

## Requirements
- R1: For an in-range request, address bits [28:27] hold the size code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = page mode.
- R2: For an in-range request, address bits [31:29] hold the 3-bit view code unchanged. View bit 0 mirrors X, bit 1 mirrors Y and bit 2 swaps X and Y.
- R3: The number of usable coordinate bits depends on the size code. 8-bit: X 14, Y 13. 16-bit: X 14, Y 12. 32-bit: X 13, Y 12. A coordinate equal to its all-ones limit is in range.
- R4: If X or Y is above its limit, the result flag is 0 and the whole address is 0. Otherwise the flag is 1.
- R5: Mirroring replaces a coordinate by (limit - coordinate). It is applied before any swap.
- R6: Without a swap the offset is Y times 2^(X bits) plus X. With a swap it is X times 2^(Y bits) plus Y. Both use the mirrored coordinates.
- R7: The offset is multiplied by 2^(dropped X bits + dropped Y bits). This gives 1 dropped bit for 16-bit and 2 for 32-bit, so the low address bits of those sizes are 0.
- R8: The stride is 2^(13 + dropped X bits) when swapped and 2^(14 + dropped Y bits) otherwise. It is reported for out-of-range requests as well.
- R9: out_valid rises exactly one clock after in_valid. When out_valid is low, the address, flag and stride are 0. After reset, out_valid is 0.
- R10: Page mode uses the 8-bit geometry: same limits, same offset and no scaling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_fmt | input | 2 | Pixel size code |
| in_orient | input | 3 | View code |
| in_x | input | 16 | X coordinate |
| in_y | input | 16 | Y coordinate |
| out_valid | output | 1 | Result present |
| out_ok | output | 1 | Coordinate was in range |
| out_addr | output | 32 | Tiled-space address |
| out_stride | output | 16 | Line stride of the view |

## Verification
The hardest cases to reach from the ports are the exact range limits. These limits move with the size code: a coordinate that is legal for 8-bit pixels is out of range for 32-bit pixels, and mirroring a value at its limit must give zero. The stimulus drives every size and view code with coordinates at each limit and one step above it. A pseudo-random sweep then mixes coordinates near the shrinking ranges, so that range rejection and mirroring are exercised together in back-to-back and gapped requests.

// File: rtl/tv_pkg.sv
package tv_pkg;
    typedef enum logic [1:0] {
        TV_FMT_8    = 2'd0,
        TV_FMT_16   = 2'd1,
        TV_FMT_32   = 2'd2,
        TV_FMT_PAGE = 2'd3
    } tv_fmt_e;

    // bit positions inside the view code
    localparam int VIEW_XMIR = 0;
    localparam int VIEW_YMIR = 1;
    localparam int VIEW_SWAP = 2;
    localparam int VIEW_W    = 3;
    localparam int FMT_W     = 2;
endpackage

// File: rtl/tv_geom.sv
module tv_geom #(
    parameter int X_BITS  = 14,
    parameter int Y_BITS  = 13,
    parameter int COORD_W = 16,
    parameter int SH_W    = 5
) (
    input  logic [1:0]         fmt,
    output logic [SH_W-1:0]    drop_x,
    output logic [SH_W-1:0]    drop_y,
    output logic [SH_W-1:0]    width_x,
    output logic [SH_W-1:0]    width_y,
    output logic [COORD_W-1:0] lim_x,
    output logic [COORD_W-1:0] lim_y
);
    import tv_pkg::*;

    always_comb begin
        drop_x = '0;
        drop_y = '0;
        unique case (tv_fmt_e'(fmt))
            TV_FMT_16: drop_y = SH_W'(1);
            TV_FMT_32: begin
                drop_x = SH_W'(1);
                drop_y = SH_W'(1);
            end
            default: ;   // 8-bit and page mode keep every bit
        endcase
        width_x = SH_W'(X_BITS) - drop_x;
        width_y = SH_W'(Y_BITS) - drop_y;
        lim_x   = ~({COORD_W{1'b1}} << width_x);
        lim_y   = ~({COORD_W{1'b1}} << width_y);
    end
endmodule

// File: rtl/tv_xform.sv
module tv_xform #(
    parameter int COORD_W = 16,
    parameter int OFF_W   = 27,
    parameter int SH_W    = 5
) (
    input  logic [COORD_W-1:0] x_in,
    input  logic [COORD_W-1:0] y_in,
    input  logic [2:0]         view,
    input  logic [SH_W-1:0]    width_x,
    input  logic [SH_W-1:0]    width_y,
    input  logic [COORD_W-1:0] lim_x,
    input  logic [COORD_W-1:0] lim_y,
    input  logic [SH_W-1:0]    scale,
    output logic               in_range,
    output logic [OFF_W-1:0]   offset
);
    import tv_pkg::*;

    logic [COORD_W-1:0] x_m, y_m;
    logic [OFF_W-1:0]   x_e, y_e, packed_pos;

    always_comb begin
        in_range   = (x_in <= lim_x) && (y_in <= lim_y);
        x_m        = x_in ^ (view[VIEW_XMIR] ? lim_x : '0);
        y_m        = y_in ^ (view[VIEW_YMIR] ? lim_y : '0);
        x_e        = OFF_W'(x_m);
        y_e        = OFF_W'(y_m);
        if (view[VIEW_SWAP])
            packed_pos = (x_e << width_y) + y_e;
        else
            packed_pos = (y_e << width_x) + x_e;
        offset     = packed_pos << scale;
    end
endmodule

// File: rtl/tv_stride.sv
module tv_stride #(
    parameter int X_BITS = 14,
    parameter int Y_BITS = 13,
    parameter int SH_W   = 5,
    parameter int STR_W  = 16
) (
    input  logic              swap,
    input  logic [SH_W-1:0]   drop_x,
    input  logic [SH_W-1:0]   drop_y,
    output logic [STR_W-1:0]  stride
);
    logic [SH_W-1:0] amt;

    always_comb begin
        amt    = swap ? (SH_W'(Y_BITS) + drop_x) : (SH_W'(X_BITS) + drop_y);
        stride = STR_W'(1) << amt;
    end
endmodule

// File: rtl/tiled_view_addr.sv
module tiled_view_addr #(
    parameter int X_BITS     = 14,
    parameter int Y_BITS     = 13,
    parameter int COORD_W    = 16,
    parameter int REGISTERED = 1,
    localparam int OFF_W     = X_BITS + Y_BITS,
    localparam int ADDR_W    = OFF_W + 5,
    localparam int STR_W     = ((X_BITS > Y_BITS) ? X_BITS : Y_BITS) + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         in_fmt,
    input  logic [2:0]         in_orient,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    output logic               out_valid,
    output logic               out_ok,
    output logic [ADDR_W-1:0]  out_addr,
    output logic [STR_W-1:0]   out_stride
);
    import tv_pkg::*;

    localparam int SH_W = $clog2(OFF_W + 1);

    typedef struct packed {
        logic              valid;
        logic              ok;
        logic [ADDR_W-1:0] addr;
        logic [STR_W-1:0]  stride;
    } res_t;

    logic [SH_W-1:0]    drop_x, drop_y, width_x, width_y, scale;
    logic [COORD_W-1:0] lim_x, lim_y;
    logic               in_range;
    logic [OFF_W-1:0]   offset;
    logic [STR_W-1:0]   stride_w;
    res_t               res_d;

    tv_geom #(.X_BITS(X_BITS), .Y_BITS(Y_BITS), .COORD_W(COORD_W), .SH_W(SH_W)) u_geom (
        .fmt(in_fmt), .drop_x(drop_x), .drop_y(drop_y),
        .width_x(width_x), .width_y(width_y), .lim_x(lim_x), .lim_y(lim_y)
    );

    assign scale = drop_x + drop_y;

    tv_xform #(.COORD_W(COORD_W), .OFF_W(OFF_W), .SH_W(SH_W)) u_xform (
        .x_in(in_x), .y_in(in_y), .view(in_orient),
        .width_x(width_x), .width_y(width_y), .lim_x(lim_x), .lim_y(lim_y),
        .scale(scale), .in_range(in_range), .offset(offset)
    );

    tv_stride #(.X_BITS(X_BITS), .Y_BITS(Y_BITS), .SH_W(SH_W), .STR_W(STR_W)) u_stride (
        .swap(in_orient[VIEW_SWAP]), .drop_x(drop_x), .drop_y(drop_y), .stride(stride_w)
    );

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.valid  = 1'b1;
            res_d.ok     = in_range;
            res_d.stride = stride_w;
            if (in_range)
                res_d.addr = {in_orient, in_fmt, offset};
        end
    end

    generate
        if (REGISTERED != 0) begin : g_reg
            res_t res_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) res_q <= '0;
                else        res_q <= res_d;
            end

            assign out_valid  = res_q.valid;
            assign out_ok     = res_q.ok;
            assign out_addr   = res_q.addr;
            assign out_stride = res_q.stride;

            assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> (!out_valid && out_addr == '0 && out_stride == '0));
            assert_fmt_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_range) |=> (out_addr[OFF_W+1:OFF_W] == $past(in_fmt)));
            assert_view_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_range) |=> (out_addr[ADDR_W-1:OFF_W+2] == $past(in_orient)));
            assert_reject_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !in_range) |=> (!out_ok && out_addr == '0));
            assert_stride_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> ($countones(out_stride) == 1));
            assert_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && out_ok && out_addr[OFF_W+1:OFF_W] == 2'd2) |-> (out_addr[1:0] == 2'b00));
        end else begin : g_comb
            assign out_valid  = res_d.valid;
            assign out_ok     = res_d.ok;
            assign out_addr   = res_d.addr;
            assign out_stride = res_d.stride;
        end
    endgenerate
endmodule

// File: tb/sim_tiled_view_addr.sv
`timescale 1ns/1ps
module sim_tiled_view_addr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_fmt = '0;
    logic [2:0]  in_orient = '0;
    logic [15:0] in_x = '0;
    logic [15:0] in_y = '0;
    logic        out_valid, out_ok;
    logic [31:0] out_addr;
    logic [15:0] out_stride;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic        ok;
        logic [31:0] addr;
        logic [15:0] stride;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    tiled_view_addr u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
        .in_orient(in_orient), .in_x(in_x), .in_y(in_y), .out_valid(out_valid),
        .out_ok(out_ok), .out_addr(out_addr), .out_stride(out_stride)
    );

    function automatic exp_t model(int f, int v, longint x, longint y, string tag);
        exp_t e;
        longint dx, dy, wx, wy, mx, my, xm, ym, off;
        dx = (f == 2) ? 1 : 0;
        dy = (f == 1 || f == 2) ? 1 : 0;
        wx = 14 - dx;
        wy = 13 - dy;
        mx = (longint'(1) << wx) - 1;
        my = (longint'(1) << wy) - 1;
        e.tag    = tag;
        e.ok     = (x <= mx) && (y <= my);
        xm       = (v % 2 == 1) ? (mx - x) : x;
        ym       = ((v / 2) % 2 == 1) ? (my - y) : y;
        off      = (v >= 4) ? (xm * (longint'(1) << wy) + ym) : (ym * (longint'(1) << wx) + xm);
        off      = off * (longint'(1) << (dx + dy));
        e.addr   = e.ok ? 32'(longint'(v) * (longint'(1) << 29) + longint'(f) * (longint'(1) << 27) + off) : 32'd0;
        e.stride = (v >= 4) ? 16'(longint'(1) << (13 + dx)) : 16'(longint'(1) << (14 + dy));
        return e;
    endfunction

    task automatic send(int f, int v, int x, int y, string tag);
        @(negedge clk);
        in_valid  = 1'b1;
        in_fmt    = 2'(f);
        in_orient = 3'(v);
        in_x      = 16'(x);
        in_y      = 16'(y);
        sb.push_back(model(f, v, longint'(x), longint'(y), tag));
    endtask

    task automatic idle_check();
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_addr !== 32'd0 || out_stride !== 16'd0) begin
            n_fail++;
            $display("FAIL R9 idle: valid=%0b addr=%h stride=%h expected 0 0 0", out_valid, out_addr, out_stride);
        end
    endtask

    // monitor: pop the oldest expectation whenever a result appears
    always @(negedge clk) begin
        if (rst_n && out_valid === 1'b1) begin
            n_checks++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R9 unexpected result addr=%h expected none", out_addr);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (out_ok !== e.ok || out_addr !== e.addr || out_stride !== e.stride) begin
                    n_fail++;
                    $display("FAIL %s: ok=%0b addr=%h stride=%h expected ok=%0b addr=%h stride=%h",
                             e.tag, out_ok, out_addr, out_stride, e.ok, e.addr, e.stride);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        lfsr = 32'hACE1_1234;

        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_addr !== 32'd0) begin
            n_fail++;
            $display("FAIL R9 reset: valid=%0b addr=%h expected 0 0", out_valid, out_addr);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 after reset: valid=%0b expected 0", out_valid);
        end

        // R1 size code field, R10 page mode equals 8-bit geometry
        for (int f = 0; f < 4; f++) send(f, 0, 5, 3, "R1 size field");
        send(3, 0, 16383, 8191, "R10 page limits");
        send(3, 5, 1234, 777, "R10 page view");
        send(0, 5, 1234, 777, "R10 8-bit twin");
        idle_check();

        // R2 view field, R5 mirroring, R6 swap
        for (int v = 0; v < 8; v++) send(0, v, 0, 0, "R5 mirror origin");
        for (int v = 0; v < 8; v++) send(1, v, 100, 200, "R2 view field");
        for (int v = 4; v < 8; v++) send(2, v, 3, 7, "R6 swapped pack");
        idle_check();

        // R3 / R4 limits per size code
        send(0, 0, 16383, 8191, "R3 8-bit at limit");
        send(0, 0, 16384, 0,    "R4 8-bit X over");
        send(0, 3, 0, 8192,     "R4 8-bit Y over");
        send(1, 0, 16383, 4095, "R3 16-bit at limit");
        send(1, 1, 0, 4096,     "R4 16-bit Y over");
        send(2, 0, 8191, 4095,  "R3 32-bit at limit");
        send(2, 7, 8192, 0,     "R4 32-bit X over");
        send(2, 6, 0, 4096,     "R4 32-bit Y over");
        send(2, 3, 8191, 4095,  "R5 mirror at limit");
        send(0, 2, 65535, 65535, "R4 max input");

        // R7 scaling and R8 stride for each size and swap
        send(1, 0, 1, 1, "R7 16-bit scale");
        send(2, 0, 1, 1, "R7 32-bit scale");
        send(2, 4, 1, 1, "R8 32-bit swapped stride");
        send(1, 4, 1, 1, "R8 16-bit swapped stride");
        idle_check();

        // pseudo-random sweep, back-to-back with occasional gaps
        for (int f = 0; f < 4; f++) begin
            for (int v = 0; v < 8; v++) begin
                for (int k = 0; k < 6; k++) begin
                    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                    send(f, v, int'(lfsr[13:0]), int'(lfsr[29:17]), "R6 sweep");
                end
                if (v == 3) idle_check();
            end
        end
        idle_check();
        repeat (2) @(negedge clk);

        n_checks++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R9 missing results: %0d pending expected 0", sb.size());
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule